// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block works out where an instruction's memory operand lives. Each cycle in which `issue` is high, it reads an addressing-mode code, a displacement taken from the instruction, and the selects for a base pointer, an index pointer and a single pointer. From these it forms a 16-bit offset. It then picks the data or the stack segment start and forms a 20-bit physical address. The block holds four 16-bit pointer registers: a data-side base, a stack-side base and two index registers. A load port writes them. The auto-increment and auto-decrement modes change the selected pointer themselves.

Results are registered. The offset, the physical address and the illegal flag appear one cycle after the issue, together with `out_valid`. Any pointer update caused by that issue takes effect on the same clock edge. A decoder drives one request per cycle and feeds the physical address to the memory port.

Top module: `operand_addr_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_offset`, `out_phys` and `out_illegal` are zero and all four pointer registers read zero.
- R2: Mode code 0 (direct) gives an offset equal to the extended displacement. It uses the data segment.
- R3: When `disp_wide` is 0, only `disp[7:0]` is used, sign-extended to 16 bits. When it is 1, all 16 bits are used. All offset arithmetic wraps modulo 65536.
- R4: Mode code 1 (register indirect) gives an offset equal to the pointer chosen by `ptr_sel` (0 data base, 1 stack base, 2 index 0, 3 index 1).
- R5: Mode code 2 (based) adds the base chosen by `base_sel` (0 data base, 1 stack base) to the displacement. Mode code 3 (indexed) adds the index chosen by `idx_sel` (0 index 0, 1 index 1) to the displacement. Mode code 4 (based-indexed) adds base, index and displacement.
- R6: The stack segment is used exactly when the offset is built from the stack base. That is modes 2 and 4 with `base_sel`=1, or modes 1, 5 and 6 with `ptr_sel`=1. Every other case uses the data segment.
- R7: `out_phys` = segment × 16 + offset, truncated to 20 bits.
- R8: Mode code 5 (auto-increment) issues the pointer's current value as the offset. On the same edge, the pointer advances by the step.
- R9: Mode code 6 (auto-decrement) lowers the pointer by the step. The lowered value is issued as the offset, and the same value is stored.
- R10: The step is 2 when `word_op` is 1 and 1 when it is 0.
- R11: Mode code 7 is illegal. It gives an offset and physical address of zero, sets `out_illegal`, and leaves every pointer unchanged.
- R12: Outputs update one cycle after an issue, and `out_valid` follows `issue` with one cycle of delay. Without an issue, the offset, address and flag hold their values.
- R13: `ld_en` writes `ld_data` into the pointer chosen by `ld_sel`. A load wins over an auto-update of the same pointer on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Compute an address this cycle |
| mode | input | 3 | Addressing-mode code |
| disp | input | 16 | Instruction displacement |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit sign-extended |
| base_sel | input | 1 | Base pointer for modes 2 and 4 |
| idx_sel | input | 1 | Index pointer for modes 3 and 4 |
| ptr_sel | input | 2 | Pointer for modes 1, 5 and 6 |
| word_op | input | 1 | Operand size: 1 word, 0 byte |
| seg_data | input | 16 | Data segment start |
| seg_stack | input | 16 | Stack segment start |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_data | input | 16 | Load value |
| out_valid | output | 1 | Result valid |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |
| out_illegal | output | 1 | Unused mode code seen |

## Verification
The chained auto-increment and auto-decrement properties apply only when two consecutive issues name the same pointer and operand size, and no load reaches that pointer on the first issue's edge. They also assume `issue` is never high during reset. The direct-mode property assumes the segment and displacement inputs are stable across the sampling edge. The bench drives every input at the falling edge and drops `issue` right after the rising edge, so each request is sampled exactly once.

// File: rtl/oau_pkg.sv
package oau_pkg;
    localparam int OFS_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PHYS_W    = OFS_W + SEG_SHIFT;
    localparam int NARROW_W  = 8;
    localparam int NPTR      = 4;
    localparam int PSEL_W    = $clog2(NPTR);

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_INDIRECT = 3'd1,
        AM_BASED    = 3'd2,
        AM_INDEXED  = 3'd3,
        AM_BASE_IDX = 3'd4,
        AM_POST_INC = 3'd5,
        AM_PRE_DEC  = 3'd6,
        AM_BAD      = 3'd7
    } amode_e;

    typedef enum logic [PSEL_W-1:0] {
        PR_DBASE = 2'd0,
        PR_SBASE = 2'd1,
        PR_IDX0  = 2'd2,
        PR_IDX1  = 2'd3
    } ptr_e;

    typedef struct packed {
        logic [OFS_W-1:0]  offset;
        logic              use_stack;
        logic              wb_en;
        logic [PSEL_W-1:0] wb_sel;
        logic [OFS_W-1:0]  wb_val;
        logic              illegal;
    } ea_res_t;

    function automatic logic [OFS_W-1:0] widen_disp(input logic [OFS_W-1:0] d, input logic wide);
        return wide ? d : {{(OFS_W-NARROW_W){d[NARROW_W-1]}}, d[NARROW_W-1:0]};
    endfunction

    function automatic logic [OFS_W-1:0] size_step(input logic word);
        return word ? OFS_W'(2) : OFS_W'(1);
    endfunction
endpackage

// File: rtl/oau_ptr_file.sv
module oau_ptr_file
    import oau_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ld_en,
    input  logic [PSEL_W-1:0]           ld_sel,
    input  logic [OFS_W-1:0]            ld_data,
    input  logic                        upd_en,
    input  logic [PSEL_W-1:0]           upd_sel,
    input  logic [OFS_W-1:0]            upd_val,
    output logic [NPTR-1:0][OFS_W-1:0]  ptrs
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptrs[g] <= '0;
            else if (ld_en && ld_sel == PSEL_W'(g))
                ptrs[g] <= ld_data;
            else if (upd_en && upd_sel == PSEL_W'(g))
                ptrs[g] <= upd_val;
        end
    end
endmodule

// File: rtl/oau_offset_calc.sv
module oau_offset_calc
    import oau_pkg::*;
(
    input  logic [2:0]                 mode,
    input  logic [OFS_W-1:0]           disp,
    input  logic                       disp_wide,
    input  logic                       base_sel,
    input  logic                       idx_sel,
    input  logic [PSEL_W-1:0]          ptr_sel,
    input  logic                       word_op,
    input  logic [NPTR-1:0][OFS_W-1:0] ptrs,
    output ea_res_t                    res
);
    logic [OFS_W-1:0] d_x, base_v, idx_v, ptr_v, step;

    always_comb begin
        d_x    = widen_disp(disp, disp_wide);
        base_v = base_sel ? ptrs[PR_SBASE] : ptrs[PR_DBASE];
        idx_v  = idx_sel  ? ptrs[PR_IDX1]  : ptrs[PR_IDX0];
        ptr_v  = ptrs[ptr_sel];
        step   = size_step(word_op);
        res    = '0;
        res.wb_sel = ptr_sel;
        unique case (amode_e'(mode))
            AM_DIRECT:   res.offset = d_x;
            AM_INDIRECT: begin
                res.offset    = ptr_v;
                res.use_stack = (ptr_sel == PR_SBASE);
            end
            AM_BASED: begin
                res.offset    = base_v + d_x;
                res.use_stack = base_sel;
            end
            AM_INDEXED:  res.offset = idx_v + d_x;
            AM_BASE_IDX: begin
                res.offset    = base_v + idx_v + d_x;
                res.use_stack = base_sel;
            end
            AM_POST_INC: begin
                res.offset    = ptr_v;
                res.use_stack = (ptr_sel == PR_SBASE);
                res.wb_en     = 1'b1;
                res.wb_val    = ptr_v + step;
            end
            AM_PRE_DEC: begin
                res.offset    = ptr_v - step;
                res.use_stack = (ptr_sel == PR_SBASE);
                res.wb_en     = 1'b1;
                res.wb_val    = ptr_v - step;
            end
            default:     res.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/oau_phys_calc.sv
module oau_phys_calc
    import oau_pkg::*;
(
    input  logic [OFS_W-1:0]  seg,
    input  logic [OFS_W-1:0]  offset,
    output logic [PHYS_W-1:0] phys
);
    assign phys = (PHYS_W'(seg) << SEG_SHIFT) + PHYS_W'(offset);
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
    import oau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [2:0]        mode,
    input  logic [15:0]       disp,
    input  logic              disp_wide,
    input  logic              base_sel,
    input  logic              idx_sel,
    input  logic [1:0]        ptr_sel,
    input  logic              word_op,
    input  logic [15:0]       seg_data,
    input  logic [15:0]       seg_stack,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [15:0]       ld_data,
    output logic              out_valid,
    output logic [15:0]       out_offset,
    output logic [19:0]       out_phys,
    output logic              out_illegal
);
    logic [NPTR-1:0][OFS_W-1:0] ptrs;
    ea_res_t                    res;
    logic [OFS_W-1:0]           seg_pick;
    logic [PHYS_W-1:0]          phys_c;

    oau_ptr_file u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .upd_en  (issue && res.wb_en),
        .upd_sel (res.wb_sel),
        .upd_val (res.wb_val),
        .ptrs    (ptrs)
    );

    oau_offset_calc u_ofs (
        .mode      (mode),
        .disp      (disp),
        .disp_wide (disp_wide),
        .base_sel  (base_sel),
        .idx_sel   (idx_sel),
        .ptr_sel   (ptr_sel),
        .word_op   (word_op),
        .ptrs      (ptrs),
        .res       (res)
    );

    assign seg_pick = res.use_stack ? seg_stack : seg_data;

    oau_phys_calc u_phys (
        .seg    (seg_pick),
        .offset (res.offset),
        .phys   (phys_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_offset  <= '0;
            out_phys    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= issue;
            if (issue) begin
                out_offset  <= res.offset;
                out_phys    <= res.illegal ? '0 : phys_c;
                out_illegal <= res.illegal;
            end
        end
    end
endmodule

// File: rtl/oau_checker.sv
module oau_checker
    import oau_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        issue,
    input logic [2:0]  mode,
    input logic [15:0] disp,
    input logic        disp_wide,
    input logic [1:0]  ptr_sel,
    input logic        word_op,
    input logic [15:0] seg_data,
    input logic        ld_en,
    input logic [1:0]  ld_sel,
    input logic        out_valid,
    input logic [15:0] out_offset,
    input logic [19:0] out_phys,
    input logic        out_illegal
);
    a_r12_valid_tracks_issue: assert property (@(posedge clk) disable iff (rst)
        issue |=> out_valid);

    a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !out_valid && $stable(out_offset) && $stable(out_phys) && $stable(out_illegal));

    a_r11_illegal_zeroes: assert property (@(posedge clk) disable iff (rst)
        (issue && mode == 3'd7) |=> out_illegal && out_offset == '0 && out_phys == '0);

    a_r2_direct_wide: assert property (@(posedge clk) disable iff (rst)
        (issue && mode == 3'd0 && disp_wide) |=>
            out_offset == $past(disp) &&
            out_phys == (PHYS_W'($past(seg_data)) << SEG_SHIFT) + PHYS_W'($past(disp)));

    a_r8_inc_chain: assert property (@(posedge clk) disable iff (rst)
        (issue && mode == 3'd5 && !$past(rst) && $past(issue) && $past(mode) == 3'd5 &&
         $past(ptr_sel) == ptr_sel && $past(word_op) == word_op &&
         !($past(ld_en) && $past(ld_sel) == ptr_sel)) |=>
            out_offset == $past(out_offset) + size_step($past(word_op)));

    a_r9_dec_chain: assert property (@(posedge clk) disable iff (rst)
        (issue && mode == 3'd6 && !$past(rst) && $past(issue) && $past(mode) == 3'd6 &&
         $past(ptr_sel) == ptr_sel && $past(word_op) == word_op &&
         !($past(ld_en) && $past(ld_sel) == ptr_sel)) |=>
            out_offset == $past(out_offset) - size_step($past(word_op)));
endmodule

bind operand_addr_unit oau_checker u_chk (.*);

// File: tb/operand_addr_unit_test.sv
module operand_addr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] disp = '0;
    logic        disp_wide = 1'b0, base_sel = 1'b0, idx_sel = 1'b0, word_op = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [15:0] seg_data = 16'h2000, seg_stack = 16'h3000;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic        out_valid, out_illegal;
    logic [15:0] out_offset;
    logic [19:0] out_phys;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    operand_addr_unit uut (
        .clk(clk), .rst(rst), .issue(issue), .mode(mode), .disp(disp),
        .disp_wide(disp_wide), .base_sel(base_sel), .idx_sel(idx_sel),
        .ptr_sel(ptr_sel), .word_op(word_op), .seg_data(seg_data),
        .seg_stack(seg_stack), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .out_valid(out_valid), .out_offset(out_offset), .out_phys(out_phys),
        .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic [15:0] dsp;
        logic        wide;
        logic        bs;
        logic        is;
        logic [1:0]  ps;
        logic [15:0] e_off;
        logic [19:0] e_phys;
        logic        e_ill;
    } vec_t;

    // Pointers preloaded: dbase=0301 sbase=1000 idx0=0020 idx1=FFF0
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 16'h1234, 1'b1, 1'b0, 1'b0, 2'd0, 16'h1234, 20'h21234, 1'b0}, // R2
        '{3'd2, 16'h0005, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0306, 20'h20306, 1'b0}, // R5
        '{3'd2, 16'h00FE, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0FFE, 20'h30FFE, 1'b0}, // R3 R6
        '{3'd3, 16'h0100, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0120, 20'h20120, 1'b0}, // R5
        '{3'd4, 16'h0020, 1'b1, 1'b0, 1'b1, 2'd0, 16'h0311, 20'h20311, 1'b0}, // R5 R3 wrap
        '{3'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 16'h1000, 20'h31000, 1'b0}, // R4 R6
        '{3'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 16'hFFF0, 20'h2FFF0, 1'b0}, // R4
        '{3'd7, 16'h1111, 1'b1, 1'b1, 1'b1, 2'd1, 16'h0000, 20'h00000, 1'b1}, // R11
        '{3'd0, 16'h0080, 1'b0, 1'b0, 1'b0, 2'd0, 16'hFF80, 20'h2FF80, 1'b0}, // R3
        '{3'd4, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd0, 16'h1020, 20'h31020, 1'b0}  // R5 R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic op(input logic [2:0] m, input logic [15:0] d, input logic w,
                      input logic bs, input logic is, input logic [1:0] ps,
                      input logic wd, input logic lden, input logic [15:0] ldv);
        @(negedge clk);
        issue = 1'b1; mode = m; disp = d; disp_wide = w; base_sel = bs;
        idx_sel = is; ptr_sel = ps; word_op = wd;
        ld_en = lden; ld_sel = ps; ld_data = ldv;
        @(posedge clk); #1;
        issue = 1'b0; ld_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] ps, input logic [15:0] exp, input string req);
        op(3'd1, 16'h0, 1'b0, 1'b0, 1'b0, ps, 1'b0, 1'b0, 16'h0);
        check(req, 32'(out_offset), 32'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 valid", 32'(out_valid), 0);
        check("R1 offset", 32'(out_offset), 0);
        check("R1 phys", 32'(out_phys), 0);
        check("R1 illegal", 32'(out_illegal), 0);
        peek(2'd0, 16'h0000, "R1 pointer zero");

        load(2'd0, 16'h0301);
        load(2'd1, 16'h1000);
        load(2'd2, 16'h0020);
        load(2'd3, 16'hFFF0);
        peek(2'd2, 16'h0020, "R13 load");

        for (int i = 0; i < NVEC; i++) begin
            op(VECS[i].md, VECS[i].dsp, VECS[i].wide, VECS[i].bs, VECS[i].is,
               VECS[i].ps, 1'b0, 1'b0, 16'h0);
            check($sformatf("R12 vec%0d valid", i), 32'(out_valid), 1);
            check($sformatf("R2-5 vec%0d offset", i), 32'(out_offset), 32'(VECS[i].e_off));
            check($sformatf("R7 vec%0d phys", i), 32'(out_phys), 32'(VECS[i].e_phys));
            check($sformatf("R11 vec%0d illegal", i), 32'(out_illegal), 32'(VECS[i].e_ill));
        end

        // R8 R10: post-increment, word then byte
        op(3'd5, 16'h0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 16'h0);
        check("R8 inc offset", 32'(out_offset), 32'h0020);
        check("R8 inc phys", 32'(out_phys), 32'h20020);
        peek(2'd2, 16'h0022, "R10 word step");
        op(3'd5, 16'h0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0);
        check("R8 inc byte offset", 32'(out_offset), 32'h0022);
        peek(2'd2, 16'h0023, "R10 byte step");

        // R9 R6: pre-decrement on stack base, word
        op(3'd6, 16'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h0);
        check("R9 dec offset", 32'(out_offset), 32'h0FFE);
        check("R6 dec stack phys", 32'(out_phys), 32'h30FFE);
        peek(2'd1, 16'h0FFE, "R9 dec stored");
        op(3'd6, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        check("R9 dec byte offset", 32'(out_offset), 32'h0300);
        check("R6 dec data phys", 32'(out_phys), 32'h20300);

        // R11: illegal code leaves pointer alone
        op(3'd7, 16'h0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 16'h0);
        check("R11 flag", 32'(out_illegal), 1);
        peek(2'd2, 16'h0023, "R11 no update");
        check("R11 flag clears", 32'(out_illegal), 0);

        // R12: hold without issue
        @(posedge clk); #1;
        check("R12 valid low", 32'(out_valid), 0);
        check("R12 offset held", 32'(out_offset), 32'h0023);

        // R13: load beats increment on same pointer
        op(3'd5, 16'h0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 16'h5000);
        check("R13 issued old", 32'(out_offset), 32'h0023);
        peek(2'd2, 16'h5000, "R13 load wins");

        // R3 R9: decrement wraps below zero
        load(2'd3, 16'h0000);
        op(3'd6, 16'h0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 16'h0);
        check("R9 wrap offset", 32'(out_offset), 32'hFFFF);
        check("R7 wrap phys", 32'(out_phys), 32'h2FFFF);

        // R7: physical address truncates to 20 bits
        seg_data = 16'hFFFF;
        op(3'd0, 16'h0020, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        check("R7 phys truncate", 32'(out_phys), 32'h00010);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule